// File: doc/BRIEF.md
# Receive Frame Length Supervisor

This block sits beside an HDLC receiver and counts the bytes of each incoming frame. When checking is switched on for a frame and the frame grows past a programmed maximum, the block stops accepting its bytes. It raises a discard level so that the receive path drops everything up to the next closing flag or abort. It also sends a one-cycle interrupt pulse to the processor. When the frame ends, it tells the frame status logic to record the frame exactly as if the far end had aborted it.

The maximum is given in units of 32 bytes: a length field value F sets a limit of (F + 1) * 32 bytes, so an 11-bit field spans 32 to 65536 bytes. The enable bit and the length field are captured at the start of each frame, and they hold for that whole frame. Flag detection, FIFO storage and register access are handled elsewhere.

Top module: `rx_len_guard`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `discard`, `irq` and `abort_ind` are all low.
- R2: A frame that starts while `chk_en` is low never raises `discard`, `irq` or `abort_ind`, whatever its length.
- R3: With checking enabled, a frame of at most (F + 1) * 32 bytes never raises `discard`, `irq` or `abort_ind`. F is the value of `max_blocks` at start of frame.
- R4: With checking enabled, `discard` is high in the same cycle as byte number (F + 1) * 32 + 1 of the frame, and `irq` is high for exactly one cycle, the cycle after that byte.
- R5: After a violation, `discard` stays high on every later byte and in the `eof` cycle, and it is low in the cycle after `eof`.
- R6: `abort_ind` pulses for one cycle, the cycle after `eof`, only for a frame that violated its limit. A frame that ended within its limit gives no pulse.
- R7: Changing `chk_en` or `max_blocks` in the middle of a frame has no effect on that frame. The values seen in the `sof` cycle govern it.
- R8: The byte counter saturates rather than wrapping. At the largest field value (2047), byte 65536 is accepted and byte 65537 is a violation.
- R9: `sof` is asserted together with the frame's first `byte_stb`, and that byte counts as byte 1. After a violated frame, the next frame is checked afresh against its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_stb | input | 1 | One received byte is present this cycle |
| sof | input | 1 | Start of frame, given with the first byte |
| eof | input | 1 | Frame ended by a closing flag or an abort |
| chk_en | input | 1 | Length checking on, sampled at `sof` |
| max_blocks | input | FIELD_W | Limit field F, limit = (F+1)*32 bytes, sampled at `sof` |
| discard | output | 1 | Drop the byte of this cycle and all later bytes until the frame ends |
| irq | output | 1 | One-cycle interrupt on a length violation |
| abort_ind | output | 1 | One-cycle pulse after `eof`: report the frame as remotely aborted |

## Verification
On every cycle the assertions check that `irq` lasts exactly one cycle and always follows a byte strobe. They also check that `discard` holds until the frame ends, that `abort_ind` follows `eof`, that a frame with checking off stays quiet, and that the counter never wraps back to zero. Only the bench's scenarios can show that the limit lands on exactly byte (F+1)*32 + 1 for each field value, and that settings changed in the middle of a frame are ignored. The full 65536-byte boundary is likewise shown only by the bench.

// File: rtl/rx_len_guard.sv
module rx_len_guard #(
  parameter int FIELD_W  = 11,
  parameter int BLK_LOG2 = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               byte_stb,
  input  logic               sof,
  input  logic               eof,
  input  logic               chk_en,
  input  logic [FIELD_W-1:0] max_blocks,
  output logic               discard,
  output logic               irq,
  output logic               abort_ind
);
  localparam int CNT_W = FIELD_W + BLK_LOG2 + 1;

  logic [CNT_W-1:0] cnt_q, lim_q, blk_ext, lim_new, lim_eff, cnt_eff, cnt_nxt;
  logic en_q, viol_q, in_frm_q;
  logic en_eff, live, viol_live, hit;

  assign blk_ext   = {{(CNT_W-FIELD_W){1'b0}}, max_blocks};
  assign lim_new   = (blk_ext + 1'b1) << BLK_LOG2;
  assign en_eff    = sof ? chk_en  : en_q;
  assign lim_eff   = sof ? lim_new : lim_q;
  assign cnt_eff   = sof ? '0      : cnt_q;
  assign live      = sof | in_frm_q;
  assign viol_live = viol_q & ~sof;
  assign hit       = byte_stb & live & en_eff & ~viol_live & (cnt_eff == lim_eff);
  assign discard   = hit | viol_live;
  assign cnt_nxt   = (byte_stb && cnt_eff != '1) ? cnt_eff + 1'b1 : cnt_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      en_q      <= 1'b0;
      viol_q    <= 1'b0;
      in_frm_q  <= 1'b0;
      irq       <= 1'b0;
      abort_ind <= 1'b0;
    end else begin
      if (sof) begin
        en_q  <= chk_en;
        lim_q <= lim_new;
      end
      cnt_q     <= cnt_nxt;
      in_frm_q  <= sof | (in_frm_q & ~eof);
      viol_q    <= ~eof & discard;
      irq       <= hit;
      abort_ind <= eof & discard;
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);                                                  // R4
  AST_IRQ_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(byte_stb));                                       // R4
  AST_DISCARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (discard && !eof && !sof) |=> (discard || sof));                // R5
  AST_ABORT_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ind |-> $past(eof));                                      // R6
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !sof) |-> !discard);                                  // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !sof) |=> cnt_q != '0);                         // R8
endmodule

// File: tb/rx_len_guard_tb_top.sv
module rx_len_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic byte_stb = 0, sof = 0, eof = 0, chk_en = 0;
  logic [FW-1:0] max_blocks = '0;
  logic discard, irq, abort_ind;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_len_guard #(.FIELD_W(FW), .BLK_LOG2(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .sof(sof), .eof(eof),
    .chk_en(chk_en), .max_blocks(max_blocks),
    .discard(discard), .irq(irq), .abort_ind(abort_ind));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic next_cycle();
    @(posedge clk); #1;
  endtask

  // R3 R4 R5 R6 R7 R9 checked in each frame
  task automatic frame(input int fld, input bit en, input int len, input bit flip);
    int lim = (fld + 1) * 32;
    bit viol = en && (len > lim);
    string rq = en ? "R4" : "R2";
    for (int i = 1; i <= len; i++) begin
      byte_stb = 1; sof = (i == 1); eof = 0;
      if (i == 1) begin chk_en = en; max_blocks = FW'(fld); end
      if (flip && i == 2) begin chk_en = !en; max_blocks = ~FW'(fld); end
      #2;
      chk(viol ? rq : (en ? "R3" : "R2"), "discard", int'(discard), int'(en && i > lim));
      chk(flip ? "R7" : (i == 1 ? "R9" : rq), "irq", int'(irq), int'(en && i == lim + 2));
      next_cycle();
    end
    byte_stb = 0; sof = 0; eof = 1;
    #2;
    chk("R5", "discard at eof", int'(discard), int'(viol));
    chk("R4", "irq at eof", int'(irq), int'(en && len == lim + 1));
    next_cycle();
    eof = 0;
    #2;
    chk("R6", "abort_ind", int'(abort_ind), int'(viol));
    chk("R5", "discard after eof", int'(discard), 0);
    chk("R4", "irq after eof", int'(irq), 0);
    next_cycle();
    #2;
    chk("R6", "abort_ind single", int'(abort_ind), 0);
    next_cycle();
  endtask

  initial begin
    #3;
    chk("R1", "discard in reset", int'(discard), 0);
    chk("R1", "irq in reset", int'(irq), 0);
    chk("R1", "abort in reset", int'(abort_ind), 0);
    next_cycle();
    rst_n = 1;
    next_cycle();
    chk("R1", "discard after reset", int'(discard), 0);
    chk("R1", "irq after reset", int'(irq), 0);
    chk("R1", "abort after reset", int'(abort_ind), 0);
    for (int f = 0; f < 4; f++)
      for (int e = 0; e < 2; e++) begin
        int lim = (f + 1) * 32;
        frame(f, e[0], 1, 0);
        frame(f, e[0], lim - 1, 0);
        frame(f, e[0], lim, 0);
        frame(f, e[0], lim + 1, 0);
        frame(f, e[0], lim + 5, 0);
        frame(f, e[0], lim + 3, 1);
        frame(f, e[0], lim, 1);
      end
    frame(2047, 1, 65537, 0); // R8 largest limit
    frame(0, 1, 40, 0);       // R9 re-arm after violation
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule